// File: doc/BRIEF.md
# SRAM Stream Read Bridge

The bridge gives a 64-bit register bus read access to a local SRAM through four registers: an address register, a mode-set register, a mode-clear register and a data port. Software writes a byte address into the upper half of the address register and then reads the data port. Each read returns one 64-bit SRAM word. When stream mode is on, each read also moves an internal word pointer forward by 8 bytes, so a run of data-port reads walks through memory without any further address writes.

The pointer wraps in one of two ways. In circular mode it wraps inside an aligned window of `2**WIN_AW` bytes. In linear mode it wraps only at the end of the SRAM. A misaligned address write is dropped and raises a sticky error flag.

Two variants are chosen by the `FIXED_VIEW` parameter:

- **Tracking variant (0):** the address register takes a system address. The block subtracts `SRAM_BASE` from it. Reading the register back returns the system address of the next word to be read.
- **Fixed-view variant (1):** the address register takes an offset that software has already made SRAM-relative. Reading it back always returns the value that was written, while a hidden pointer advances.

Control is a two-state machine:

- **ST_IDLE** accepts one strobe.
  - A register access or a data-port write goes `ST_IDLE -> ST_IDLE` and is acknowledged on the next cycle.
  - A data-port read issues the SRAM read and goes `ST_IDLE -> ST_FETCH`.
- **ST_FETCH** captures the SRAM word, acknowledges, advances the pointer if stream mode is on, and returns `ST_FETCH -> ST_IDLE`.
- Strobes that arrive while the machine is in ST_FETCH are ignored.

Top module: `sram_stream_bridge`

## Requirements
- R1: After reset, the mode word reads 0 (stream off, circular, no error) and the word pointer is at SRAM offset 0. In the tracking variant the address register therefore reads `{SRAM_BASE, 32'h0}`.
- R2: Mode bits are bit 0 = stream and bit 1 = linear. Writing 1s to the set register (select 1) turns bits on, and writing 1s to the clear register (select 2) turns bits off. Reading either register returns `{err, linear, stream}` in bits 2..0. Writing a 1 to bit 2 of the set register has no effect.
- R3: Register selects are 0 = address, 1 = mode set, 2 = mode clear and 3 = data port. The address is taken from `bus_wdata[63:32]`. In the tracking variant the SRAM byte offset is that value minus `SRAM_BASE`, truncated to `AW` bits.
- R4: An address write with bits [34:32] nonzero leaves the pointer unchanged and sets the error flag (mode bit 2). The flag stays set until a 1 is written to bit 2 of the clear register.
- R5: With stream on, a data-port read returns the SRAM word at the pointer, and the pointer then advances by one word (8 bytes).
- R6: With stream off, a data-port read returns the word at the pointer and leaves the pointer unchanged.
- R7: In the tracking variant, reading the address register returns `{SRAM_BASE + next byte offset, 32'h0}`.
- R8: In the fixed-view variant, the address register reads back the value last written, and stream reads still advance through memory.
- R9: In circular mode the pointer steps modulo the window, so the word after the last word of a window is the first word of that same window.
- R10: In linear mode the pointer wraps from the last SRAM word to offset 0.
- R11: `bus_ack` is high one cycle after a register-access strobe and two cycles after a data-port read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 64 | Write data |
| bus_ack | output | 1 | Access done pulse |
| bus_rdata | output | 64 | Read data, valid with `bus_ack` |
| sram_re | output | 1 | SRAM read enable |
| sram_addr | output | AW-3 | SRAM word index |
| sram_rdata | input | 64 | SRAM data, one cycle after `sram_re` |

## Verification
Because the SRAM model returns a different word for every index, each read shows which word the pointer pointed at.

Runs of reads are made in several settings, and each setting distinguishes a different behaviour:

- **Stream off:** repeated reads of the same word separate a held pointer from an advancing one.
- **Stream on, mid-memory:** the read sequence confirms the 8-byte step.
- **Circular mode, window's last word:** a start there separates a wrap within the window from a run-on into the next window.
- **Linear mode, SRAM's last word:** a start there separates a wrap to offset 0 from a wrap within the window.

Reading the address register back after each run tells the tracking view from the fixed view. A misaligned address write followed by a pointer readback shows that the write was dropped.

// File: rtl/srb_pkg.sv
package srb_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_MSET = 2'd1,
        SEL_MCLR = 2'd2,
        SEL_DATA = 2'd3
    } srb_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } srb_state_e;

    localparam int MB_STREAM = 0;
    localparam int MB_LINEAR = 1;
    localparam int MB_ERR    = 2;
endpackage

// File: rtl/srb_step.sv
module srb_step #(
    parameter int WAW = 9,
    parameter int WW  = 5
) (
    input  logic [WAW-1:0] cur,
    input  logic           linear,
    output logic [WAW-1:0] nxt
);
    logic [WAW-1:0] lin_nxt;
    assign lin_nxt = cur + 1'b1;

    generate
        if (WW >= WAW) begin : g_full_window
            assign nxt = lin_nxt;
        end else begin : g_split_window
            logic [WW-1:0] low_nxt;
            assign low_nxt = cur[WW-1:0] + 1'b1;
            assign nxt = linear ? lin_nxt : {cur[WAW-1:WW], low_nxt};
        end
    endgenerate
endmodule

// File: rtl/srb_ptr.sv
module srb_ptr #(
    parameter int          AW         = 12,
    parameter int          WAW        = AW - 3,
    parameter bit          FIXED_VIEW = 1'b0,
    parameter logic [31:0] SRAM_BASE  = 32'hFFFF_8000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [31:0]    load_val,
    input  logic           adv,
    input  logic [WAW-1:0] nxt_idx,
    output logic [WAW-1:0] idx,
    output logic [31:0]    view
);
    logic [31:0] eff_off;

    generate
        if (FIXED_VIEW) begin : g_fixed
            logic [31:0] held_q;
            assign eff_off = load_val;
            always_ff @(posedge clk) begin
                if (!rst_n)    held_q <= '0;
                else if (load) held_q <= load_val;
            end
            assign view = held_q;
        end else begin : g_track
            assign eff_off = load_val - SRAM_BASE;
            assign view = SRAM_BASE + {{(32-AW){1'b0}}, idx, 3'b000};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= eff_off[AW-1:3];
        else if (adv)  idx <= nxt_idx;
    end

    AST_ADV_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (idx != $past(idx))); // R5
endmodule

// File: rtl/sram_stream_bridge.sv
module sram_stream_bridge
    import srb_pkg::*;
#(
    parameter int          AW         = 12,
    parameter int          WIN_AW     = 8,
    parameter bit          FIXED_VIEW = 1'b0,
    parameter logic [31:0] SRAM_BASE  = 32'hFFFF_8000,
    localparam int         WAW        = AW - 3,
    localparam int         WW         = WIN_AW - 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_req,
    input  logic           bus_we,
    input  logic [1:0]     bus_sel,
    input  logic [63:0]    bus_wdata,
    output logic           bus_ack,
    output logic [63:0]    bus_rdata,
    output logic           sram_re,
    output logic [WAW-1:0] sram_addr,
    input  logic [63:0]    sram_rdata
);
    srb_state_e     state, state_nx;
    srb_sel_e       sel;
    logic           accept, is_dread, addr_wr, misalign, ptr_load, ptr_adv;
    logic           mode_stream, mode_linear, mode_err;
    logic [WAW-1:0] idx, nxt_idx;
    logic [31:0]    view;
    logic [63:0]    mode_word;

    assign sel       = srb_sel_e'(bus_sel);
    assign accept    = (state == ST_IDLE) && bus_req;
    assign is_dread  = accept && !bus_we && (sel == SEL_DATA);
    assign addr_wr   = accept && bus_we && (sel == SEL_ADDR);
    assign misalign  = bus_wdata[34:32] != 3'b000;
    assign ptr_load  = addr_wr && !misalign;
    assign ptr_adv   = (state == ST_FETCH) && mode_stream;
    assign mode_word = {61'd0, mode_err, mode_linear, mode_stream};

    srb_step #(.WAW(WAW), .WW(WW)) u_step (
        .cur(idx), .linear(mode_linear), .nxt(nxt_idx)
    );

    srb_ptr #(.AW(AW), .WAW(WAW), .FIXED_VIEW(FIXED_VIEW), .SRAM_BASE(SRAM_BASE)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(bus_wdata[63:32]),
        .adv(ptr_adv), .nxt_idx(nxt_idx), .idx(idx), .view(view)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and SRAM-side outputs
    always_comb begin
        state_nx  = state;
        sram_re   = 1'b0;
        sram_addr = idx;
        unique case (state)
            ST_IDLE: begin
                if (is_dread) begin
                    sram_re  = 1'b1;
                    state_nx = ST_FETCH;
                end
            end
            ST_FETCH: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_stream <= 1'b0;
            mode_linear <= 1'b0;
            mode_err    <= 1'b0;
        end else begin
            if (accept && bus_we && sel == SEL_MSET) begin
                mode_stream <= mode_stream | bus_wdata[MB_STREAM];
                mode_linear <= mode_linear | bus_wdata[MB_LINEAR];
            end
            if (accept && bus_we && sel == SEL_MCLR) begin
                mode_stream <= mode_stream & ~bus_wdata[MB_STREAM];
                mode_linear <= mode_linear & ~bus_wdata[MB_LINEAR];
                if (bus_wdata[MB_ERR]) mode_err <= 1'b0;
            end
            if (addr_wr && misalign) mode_err <= 1'b1;
        end
    end

    // Bus-side outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= (accept && !is_dread) || (state == ST_FETCH);
            if (state == ST_FETCH) begin
                bus_rdata <= sram_rdata;
            end else if (accept && !bus_we) begin
                unique case (sel)
                    SEL_ADDR: bus_rdata <= {view, 32'd0};
                    SEL_MSET: bus_rdata <= mode_word;
                    SEL_MCLR: bus_rdata <= mode_word;
                    SEL_DATA: bus_rdata <= bus_rdata;
                    default:  bus_rdata <= bus_rdata;
                endcase
            end
        end
    end

    AST_REG_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_dread) |=> bus_ack); // R11
    AST_FETCH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        is_dread |=> (state == ST_FETCH) ##1 bus_ack); // R11
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && !mode_stream) |=> $stable(idx)); // R6
    AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && misalign) |=> ($stable(idx) && mode_err)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err && !(accept && bus_we && sel == SEL_MCLR && bus_wdata[MB_ERR])) |=> mode_err); // R4

    generate
        if (WW < WAW) begin : g_win_chk
            AST_WIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (ptr_adv && !mode_linear && !ptr_load) |=> (idx[WAW-1:WW] == $past(idx[WAW-1:WW]))); // R9
        end
    endgenerate
endmodule

// File: tb/sram_stream_bridge_bench.sv
module sram_stream_bridge_bench;
    localparam int          AW   = 12;
    localparam int          WAW  = AW - 3;
    localparam logic [31:0] BASE = 32'hFFFF_8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req = 1'b0, we = 1'b0, tgt = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [63:0] wdata = '0;

    logic           ack_a, ack_b, re_a, re_b;
    logic [63:0]    rd_a, rd_b, sd_a, sd_b;
    logic [WAW-1:0] sa_a, sa_b;
    logic           ack;
    logic [63:0]    rdat;

    int total = 0;
    int bad = 0;

    function automatic logic [63:0] word_of(input int i);
        return {32'hC0DE_0000 ^ 32'(i), ~32'(i)};
    endfunction

    always_ff @(posedge clk) begin
        if (re_a) sd_a <= word_of(int'(sa_a));
        if (re_b) sd_b <= word_of(int'(sa_b));
    end

    sram_stream_bridge #(.AW(AW), .WIN_AW(8), .FIXED_VIEW(1'b0), .SRAM_BASE(BASE)) u_sram_stream_bridge (
        .clk(clk), .rst_n(rst_n), .bus_req(req && !tgt), .bus_we(we), .bus_sel(sel),
        .bus_wdata(wdata), .bus_ack(ack_a), .bus_rdata(rd_a),
        .sram_re(re_a), .sram_addr(sa_a), .sram_rdata(sd_a)
    );

    sram_stream_bridge #(.AW(AW), .WIN_AW(8), .FIXED_VIEW(1'b1), .SRAM_BASE(BASE)) u_sram_stream_bridge_fix (
        .clk(clk), .rst_n(rst_n), .bus_req(req && tgt), .bus_we(we), .bus_sel(sel),
        .bus_wdata(wdata), .bus_ack(ack_b), .bus_rdata(rd_b),
        .sram_re(re_b), .sram_addr(sa_b), .sram_rdata(sd_b)
    );

    assign ack  = tgt ? ack_b : ack_a;
    assign rdat = tgt ? rd_b : rd_a;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [1:0] s, input logic [63:0] d,
                          output logic [63:0] r, output int lat);
        @(negedge clk);
        req = 1'b1; we = w; sel = s; wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!ack && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        r = rdat;
    endtask

    task automatic wr(input logic [1:0] s, input logic [63:0] d);
        logic [63:0] r;
        int l;
        access(1'b1, s, d, r, l);
        check("R11 write ack latency", 64'(l), 64'd1);
    endtask

    task automatic rd(input logic [1:0] s, output logic [63:0] r);
        int l;
        access(1'b0, s, '0, r, l);
        check("R11 read ack latency", 64'(l), (s == 2'd3) ? 64'd2 : 64'd1);
    endtask

    task automatic t_reset;
        logic [63:0] r;
        rd(2'd1, r); check("R1 mode at reset", r, 64'd0);
        rd(2'd0, r); check("R1 R7 address at reset", r, {BASE, 32'd0});
    endtask

    task automatic t_modes;
        logic [63:0] r;
        wr(2'd1, 64'h3);
        rd(2'd1, r); check("R2 set stream+linear", r, 64'h3);
        wr(2'd2, 64'h1);
        rd(2'd2, r); check("R2 clear stream", r, 64'h2);
        wr(2'd1, 64'h4);
        rd(2'd1, r); check("R2 set bit2 no effect", r, 64'h2);
        wr(2'd2, 64'h2);
        rd(2'd1, r); check("R2 clear linear", r, 64'h0);
    endtask

    task automatic t_stream_off;
        logic [63:0] r;
        wr(2'd0, {BASE + 32'h40, 32'd0});
        rd(2'd3, r); check("R6 first read", r, word_of(8));
        rd(2'd3, r); check("R6 repeat read same word", r, word_of(8));
        rd(2'd0, r); check("R6 R3 address unchanged", r, {BASE + 32'h40, 32'd0});
    endtask

    task automatic t_stream_on;
        logic [63:0] r;
        wr(2'd1, 64'h1);
        wr(2'd0, {BASE + 32'h80, 32'd0});
        for (int k = 0; k < 3; k++) begin
            rd(2'd3, r); check("R5 stream word", r, word_of(16 + k));
        end
        rd(2'd0, r); check("R7 next address", r, {BASE + 32'h98, 32'd0});
    endtask

    task automatic t_misalign;
        logic [63:0] r;
        wr(2'd0, {BASE + 32'h104, 32'd0});
        rd(2'd1, r); check("R4 error flag set", r, 64'h5);
        rd(2'd0, r); check("R4 address kept", r, {BASE + 32'h98, 32'd0});
        wr(2'd0, {BASE + 32'h8, 32'd0});
        rd(2'd1, r); check("R4 flag sticky", r, 64'h5);
        wr(2'd2, 64'h4);
        rd(2'd1, r); check("R4 flag cleared", r, 64'h1);
    endtask

    task automatic t_circ;
        logic [63:0] r;
        wr(2'd0, {BASE + 32'h1F8, 32'd0});
        rd(2'd3, r); check("R9 window last word", r, word_of(63));
        rd(2'd3, r); check("R9 wrap to window start", r, word_of(32));
        rd(2'd0, r); check("R9 address in window", r, {BASE + 32'h108, 32'd0});
    endtask

    task automatic t_linear;
        logic [63:0] r;
        wr(2'd1, 64'h2);
        wr(2'd0, {BASE + 32'hF8, 32'd0});
        rd(2'd3, r); check("R10 crosses window", r, word_of(31));
        rd(2'd3, r); check("R10 next window", r, word_of(32));
        wr(2'd0, {BASE + 32'hFF8, 32'd0});
        rd(2'd3, r); check("R10 last SRAM word", r, word_of(511));
        rd(2'd0, r); check("R10 wrap to zero", r, {BASE, 32'd0});
        rd(2'd3, r); check("R10 word zero", r, word_of(0));
    endtask

    task automatic t_fixed;
        logic [63:0] r;
        tgt = 1'b1;
        wr(2'd1, 64'h1);
        wr(2'd0, {32'h0000_0200, 32'd0});
        rd(2'd3, r); check("R8 fixed first word", r, word_of(64));
        rd(2'd3, r); check("R8 fixed advances", r, word_of(65));
        rd(2'd0, r); check("R8 address held", r, {32'h0000_0200, 32'd0});
        tgt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_modes();
        t_stream_off();
        t_stream_on();
        t_misalign();
        t_circ();
        t_linear();
        t_fixed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule